// File: doc/BRIEF.md
# Dual-Mode Byte-Lane Address Mapper for Paired 40-bit RAMs

This block sits between a byte-addressed system bus and two physical RAMs. Each RAM holds 2^IDX_W locations of 40 bits, split into five byte lanes. Lanes 0 to 3 of every location always hold one 32-bit word of the main region. The main region covers 32 KB at the default size. The first half of that region lives in RAM 0 and the second half in RAM 1.

What lane 4 holds depends on a mode input. With ECC on, lane 4 stores seven check bits for the word beside it, and only the main region can be reached. The check bits come from an outside generator on `req_chk`. On reads they go back out on `rsp_chk` so an outside checker can use them. With ECC off, lane 4 of every location in both RAMs becomes a separate byte-wide region placed right after the main region. Its bytes are spread across the two RAMs. Even offsets go to RAM 0 and odd offsets go to RAM 1.

The block drives one shared location index, a one-hot RAM select, five lane write enables and a 40-bit write word. The RAMs have a one-cycle synchronous read. One cycle after each request, the block returns a response built from the selected RAM's read data. The read data is right-justified, with an error flag and a read-modify-write flag. In ECC mode a sub-word write does not modify memory. Instead it reads the addressed word and returns it with the read-modify-write flag set. The bus side then merges the new bytes, recomputes the check bits and issues a full-word write.

Top module: `dual_mode_ram_mapper`

## Requirements
- R1: While no request is presented, and after reset, `ram_cs` and `ram_we` are zero and `rsp_valid`, `rsp_err` and `rsp_rmw` are low.
- R2: A main-region byte address A (A below 2^(IDX_W+3)) selects RAM A[IDX_W+2] (`ram_cs` bit 0 for RAM 0, bit 1 for RAM 1), location A[IDX_W+1:2] and lane A[1:0]. At most one `ram_cs` bit is ever high.
- R3: `req_size` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is illegal. Main-region reads return the addressed byte, halfword or word right-justified in `rsp_rdata`. A halfword at an odd address, a word whose address is not a multiple of 4, and size 3 are all rejected: no RAM is selected and the response carries `rsp_err`.
- R4: With ECC on, a word write enables all five lanes and writes lane 4 (bits 39:32) as {1'b0, `req_chk`}, with the word in bits 31:0.
- R5: With ECC on, a byte write or an aligned halfword write to the main region enables no lane. It selects the RAM for a read, and its response raises `rsp_rmw` and returns the whole stored word and its check bits.
- R6: With ECC off, a main-region write enables only the lanes it addresses among lanes 0 to 3, never lane 4. The data appears replicated in those lanes. Write responses carry zero data.
- R7: With ECC off, extra-region offset O = A − 2^(IDX_W+3), for O below 2^(IDX_W+1), selects RAM O[0] and location {O[1], O[IDX_W:2]}. Writes enable lane 4 only, with the byte in bits 39:32. Reads return that byte in `rsp_rdata[7:0]`. Main-region words are not disturbed.
- R8: With ECC off, a halfword, word or illegal-size access to the extra region selects no RAM, writes nothing, and responds with `rsp_err` and zero data.
- R9: With ECC on, any access to the extra-region window selects no RAM and responds with `rsp_err`, zero `rsp_rdata` and zero `rsp_chk`.
- R10: With ECC on, main-region read responses carry lane 4 bits 38:32 of the selected location on `rsp_chk`. With ECC off, `rsp_chk` is zero.
- R11: Addresses above the extra-region window select no RAM and respond with `rsp_err` and zero data.
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. `rsp_err` and `rsp_rmw` are low whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_on | input | 1 | 1: lane 4 holds check bits; 0: lane 4 is the extra region |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | IDX_W+4 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Right-justified write data |
| req_chk | input | 7 | Check bits for a full-word ECC write |
| ram_cs | output | 2 | One-hot RAM select |
| ram_idx | output | IDX_W | Location index, shared by both RAMs |
| ram_we | output | 5 | Per-lane write enables |
| ram_wdata | output | 40 | Write word, lane 4 in bits 39:32 |
| ram0_rdata | input | 40 | RAM 0 read word, one cycle after select |
| ram1_rdata | input | 40 | RAM 1 read word, one cycle after select |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected |
| rsp_rmw | output | 1 | Sub-word ECC write needs a merge and rewrite |
| rsp_rdata | output | 32 | Right-justified read data |
| rsp_chk | output | 7 | Stored check bits (ECC on, main region) |

## Verification
On every cycle, the assertions check the safety side of the mapping:
- no more than one RAM is selected, and nothing is selected when idle;
- lane 4 is never written from a main-region access with ECC off;
- rejected windows and widths never reach a RAM;
- sub-word ECC writes never enable a lane;
- a response follows each request by exactly one cycle;
- error responses carry no data.

Only the scenario sweeps can show where each byte actually lands. These sweeps cover every main and extra address of a 16-location configuration. They confirm that data and check bits survive a round trip, that extra-region bytes interleave across the RAMs without touching main words, and that the word returned for a read-modify-write is the stored one.

// File: rtl/drm_pkg.sv
package drm_pkg;

    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 32;
    localparam int CHK_W   = 7;
    localparam int LANES   = 5;
    localparam int PHYS_W  = LANES * BYTE_W;
    localparam int DLANES  = DATA_W / BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RGN_MAIN  = 2'd0,
        RGN_EXTRA = 2'd1,
        RGN_NONE  = 2'd2
    } region_e;

    // State carried from the request cycle into the response cycle.
    typedef struct packed {
        logic       valid;
        logic       wr;
        logic       err;
        logic       rmw;
        logic       extra;
        logic       ecc;
        logic       ram_sel;
        logic [1:0] lane;
        size_e      size;
    } rsp_state_t;

endpackage

// File: rtl/drm_decode.sv
module drm_decode
    import drm_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [IDX_W+3:0] addr,
    output region_e          region,
    output logic             ram_sel,
    output logic [IDX_W-1:0] idx,
    output logic [1:0]       lane
);

    // Extra-region offset: one byte per lane-4 slot across both RAMs.
    logic [IDX_W:0] xoff;
    logic [1:0]     gap;
    logic           upper;

    assign xoff  = addr[IDX_W:0];
    assign gap   = addr[IDX_W+2:IDX_W+1];
    assign upper = addr[IDX_W+3];

    always_comb begin
        region  = RGN_NONE;
        ram_sel = addr[IDX_W+2];
        idx     = addr[IDX_W+1:2];
        lane    = addr[1:0];
        if (!upper) begin
            region = RGN_MAIN;
        end else if (gap == 2'b00) begin
            region  = RGN_EXTRA;
            ram_sel = xoff[0];
            idx     = {xoff[1], xoff[IDX_W:2]};
            lane    = 2'd0;
        end
    end

endmodule

// File: rtl/drm_wr_lanes.sv
module drm_wr_lanes
    import drm_pkg::*;
(
    input  region_e              region,
    input  logic [1:0]           lane,
    input  size_e                size,
    input  logic                 write,
    input  logic                 ecc_on,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CHK_W-1:0]     chk_in,
    output logic                 access,
    output logic                 err,
    output logic                 rmw,
    output logic [LANES-1:0]     we,
    output logic [PHYS_W-1:0]    phys_wdata
);

    logic [DATA_W-1:0] rep;
    logic [DLANES-1:0] mask;
    logic              aligned;

    always_comb begin
        case (size)
            SZ_BYTE: rep = {DLANES{wdata[BYTE_W-1:0]}};
            SZ_HALF: rep = {2{wdata[2*BYTE_W-1:0]}};
            default: rep = wdata;
        endcase
    end

    always_comb begin
        case (size)
            SZ_BYTE: mask = DLANES'(1) << lane;
            SZ_HALF: mask = lane[1] ? 4'b1100 : 4'b0011;
            default: mask = 4'b1111;
        endcase
    end

    always_comb begin
        case (size)
            SZ_BYTE: aligned = 1'b1;
            SZ_HALF: aligned = !lane[0];
            SZ_WORD: aligned = (lane == 2'd0);
            default: aligned = 1'b0;
        endcase
    end

    // Data lanes carry the replicated bus data.
    for (genvar g = 0; g < DLANES; g++) begin : g_dlane
        assign phys_wdata[g*BYTE_W +: BYTE_W] = rep[g*BYTE_W +: BYTE_W];
    end

    // Lane 4 carries check bits or an extra-region byte.
    assign phys_wdata[PHYS_W-1 -: BYTE_W] =
        ecc_on ? {1'b0, chk_in} : wdata[BYTE_W-1:0];

    always_comb begin
        access = 1'b0;
        err    = 1'b0;
        rmw    = 1'b0;
        we     = '0;
        unique case (region)
            RGN_MAIN: begin
                if (!aligned) begin
                    err = 1'b1;
                end else begin
                    access = 1'b1;
                    if (write) begin
                        if (ecc_on && size != SZ_WORD) begin
                            rmw = 1'b1;
                        end else begin
                            we = {ecc_on, mask};
                        end
                    end
                end
            end
            RGN_EXTRA: begin
                if (ecc_on || size != SZ_BYTE) begin
                    err = 1'b1;
                end else begin
                    access = 1'b1;
                    we     = write ? 5'b10000 : 5'b00000;
                end
            end
            default: begin
                err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/drm_rd_steer.sv
module drm_rd_steer
    import drm_pkg::*;
(
    input  rsp_state_t          st,
    input  logic [PHYS_W-1:0]   rd0,
    input  logic [PHYS_W-1:0]   rd1,
    output logic [DATA_W-1:0]   rdata,
    output logic [CHK_W-1:0]    chk
);

    logic [PHYS_W-1:0]   sel;
    logic [DATA_W-1:0]   word;
    logic [BYTE_W-1:0]   lane_byte;
    logic [2*BYTE_W-1:0] half;

    always_comb begin
        sel       = st.ram_sel ? rd1 : rd0;
        word      = sel[DATA_W-1:0];
        lane_byte = word[BYTE_W*st.lane +: BYTE_W];
        half      = st.lane[1] ? word[DATA_W-1:2*BYTE_W] : word[2*BYTE_W-1:0];
        rdata     = '0;
        chk       = '0;
        if (st.valid && !st.err) begin
            if (st.extra) begin
                if (!st.wr) begin
                    rdata = {{(DATA_W-BYTE_W){1'b0}}, sel[PHYS_W-1 -: BYTE_W]};
                end
            end else begin
                if (st.rmw) begin
                    rdata = word;
                end else if (!st.wr) begin
                    case (st.size)
                        SZ_BYTE: rdata = {{(DATA_W-BYTE_W){1'b0}}, lane_byte};
                        SZ_HALF: rdata = {{(DATA_W-2*BYTE_W){1'b0}}, half};
                        default: rdata = word;
                    endcase
                end
                if (st.ecc && (st.rmw || !st.wr)) begin
                    chk = sel[DATA_W +: CHK_W];
                end
            end
        end
    end

endmodule

// File: rtl/dual_mode_ram_mapper.sv
module dual_mode_ram_mapper
    import drm_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ecc_on,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [IDX_W+3:0]     req_addr,
    input  logic [1:0]           req_size,
    input  logic [31:0]          req_wdata,
    input  logic [6:0]           req_chk,
    output logic [1:0]           ram_cs,
    output logic [IDX_W-1:0]     ram_idx,
    output logic [4:0]           ram_we,
    output logic [39:0]          ram_wdata,
    input  logic [39:0]          ram0_rdata,
    input  logic [39:0]          ram1_rdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic                 rsp_rmw,
    output logic [31:0]          rsp_rdata,
    output logic [6:0]           rsp_chk
);

    size_e            size_in;
    region_e          dec_region;
    logic             dec_ram;
    logic [IDX_W-1:0] dec_idx;
    logic [1:0]       dec_lane;
    logic             acc_ok;
    logic             acc_err;
    logic             acc_rmw;
    logic [LANES-1:0] lane_we;
    rsp_state_t       st_d;
    rsp_state_t       st_q;

    assign size_in = size_e'(req_size);

    drm_decode #(.IDX_W(IDX_W)) u_decode (
        .addr    (req_addr),
        .region  (dec_region),
        .ram_sel (dec_ram),
        .idx     (dec_idx),
        .lane    (dec_lane)
    );

    drm_wr_lanes u_wr (
        .region     (dec_region),
        .lane       (dec_lane),
        .size       (size_in),
        .write      (req_write),
        .ecc_on     (ecc_on),
        .wdata      (req_wdata),
        .chk_in     (req_chk),
        .access     (acc_ok),
        .err        (acc_err),
        .rmw        (acc_rmw),
        .we         (lane_we),
        .phys_wdata (ram_wdata)
    );

    // Request side: RAM port is driven in the request cycle.
    assign ram_idx = dec_idx;
    assign ram_cs  = (req_valid && acc_ok) ? (dec_ram ? 2'b10 : 2'b01) : 2'b00;
    assign ram_we  = (req_valid && acc_ok) ? lane_we : '0;

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.valid   = 1'b1;
            st_d.wr      = req_write;
            st_d.err     = acc_err;
            st_d.rmw     = acc_rmw;
            st_d.extra   = (dec_region == RGN_EXTRA);
            st_d.ecc     = ecc_on;
            st_d.ram_sel = dec_ram;
            st_d.lane    = dec_lane;
            st_d.size    = size_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Response side: steer the RAM read word selected one cycle earlier.
    drm_rd_steer u_steer (
        .st    (st_q),
        .rd0   (ram0_rdata),
        .rd1   (ram1_rdata),
        .rdata (rsp_rdata),
        .chk   (rsp_chk)
    );

    assign rsp_valid = st_q.valid;
    assign rsp_err   = st_q.valid & st_q.err;
    assign rsp_rmw   = st_q.valid & st_q.rmw;

endmodule

// File: rtl/drm_checker.sv
module drm_checker #(
    parameter int IDX_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ecc_on,
    input logic              req_valid,
    input logic              req_write,
    input logic [IDX_W+3:0]  req_addr,
    input logic [1:0]        req_size,
    input logic [1:0]        ram_cs,
    input logic [4:0]        ram_we,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              rsp_rmw,
    input logic [31:0]       rsp_rdata,
    input logic [6:0]        rsp_chk
);

    localparam int MAIN_BYTES  = 2 ** (IDX_W + 3);
    localparam int EXTRA_BYTES = 2 ** (IDX_W + 1);

    logic in_main;
    logic in_extra;

    assign in_main  = int'(req_addr) < MAIN_BYTES;
    assign in_extra = int'(req_addr) >= MAIN_BYTES &&
                      int'(req_addr) < MAIN_BYTES + EXTRA_BYTES;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (ram_cs == 2'b00 && ram_we == 5'b00000));

    assert_one_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_cs));

    assert_we_needs_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we != 5'b00000) |-> (ram_cs != 2'b00));

    assert_lane4_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ecc_on && in_main) |-> !ram_we[4]);

    assert_subword_no_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && ecc_on && in_main && req_size == 2'd0)
            |-> (ram_we == 5'b00000 && ram_cs != 2'b00));

    assert_subword_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && ecc_on && in_main && req_size == 2'd0)
            |=> rsp_rmw);

    assert_extra_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ecc_on && in_extra && req_size != 2'd0)
            |-> (ram_cs == 2'b00));

    assert_extra_wide_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ecc_on && in_extra && req_size != 2'd0) |=> rsp_err);

    assert_ecc_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ecc_on && in_extra) |-> (ram_cs == 2'b00));

    assert_err_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'h0 && rsp_chk == 7'h0));

    assert_chk_zero_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(ecc_on)) |-> (rsp_chk == 7'h0));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !in_main && !in_extra) |-> (ram_cs == 2'b00));

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_err && !rsp_rmw));

endmodule

bind dual_mode_ram_mapper drm_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ecc_on    (ecc_on),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rmw   (rsp_rmw),
    .rsp_rdata (rsp_rdata),
    .rsp_chk   (rsp_chk)
);

// File: tb/dual_mode_ram_mapper_tb.sv
`timescale 1ns/1ps
module dual_mode_ram_mapper_tb;

    localparam int IW    = 4;
    localparam int DEPTH = 16;
    localparam int MAINB = 128;
    localparam int EXTB  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_on = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [6:0]  req_chk = '0;
    logic [1:0]  ram_cs;
    logic [IW-1:0] ram_idx;
    logic [4:0]  ram_we;
    logic [39:0] ram_wdata;
    logic [39:0] rdq [2];
    logic        rsp_valid, rsp_err, rsp_rmw;
    logic [31:0] rsp_rdata;
    logic [6:0]  rsp_chk;

    logic [39:0] mem     [2][DEPTH];
    logic [39:0] exp_mem [2][DEPTH];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [1:0]    cap_cs;
    logic [4:0]    cap_we;
    logic [IW-1:0] cap_idx;
    logic [39:0]   cap_wd;
    logic          r_valid, r_err, r_rmw;
    logic [31:0]   r_rdata;
    logic [6:0]    r_chk;

    always #2 clk = ~clk;

    dual_mode_ram_mapper #(.IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ecc_on(ecc_on),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .req_chk(req_chk),
        .ram_cs(ram_cs), .ram_idx(ram_idx), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram0_rdata(rdq[0]), .ram1_rdata(rdq[1]),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rmw(rsp_rmw),
        .rsp_rdata(rsp_rdata), .rsp_chk(rsp_chk)
    );

    // Behavioural RAM pair, synchronous read of the old word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 2; r++) begin
                rdq[r] <= '0;
                for (int i = 0; i < DEPTH; i++) mem[r][i] <= '0;
            end
        end else begin
            for (int r = 0; r < 2; r++) begin
                if (ram_cs[r]) begin
                    for (int l = 0; l < 5; l++)
                        if (ram_we[l]) mem[r][ram_idx][l*8 +: 8] <= ram_wdata[l*8 +: 8];
                    rdq[r] <= mem[r][ram_idx];
                end
            end
        end
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input int a, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [6:0] ck);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = 8'(a);
        req_size = sz; req_wdata = wd; req_chk = ck;
        #0.5;
        cap_cs = ram_cs; cap_we = ram_we; cap_idx = ram_idx; cap_wd = ram_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #0.5;
        r_valid = rsp_valid; r_err = rsp_err; r_rmw = rsp_rmw;
        r_rdata = rsp_rdata; r_chk = rsp_chk;
    endtask

    function automatic int m_ram(int a); return a / 64; endfunction
    function automatic int m_idx(int a); return (a % 64) / 4; endfunction
    function automatic int x_ram(int o); return o % 2; endfunction
    function automatic int x_idx(int o); return ((o / 2) % 2) * 8 + o / 4; endfunction
    function automatic logic [7:0] mbyte(int a);
        return exp_mem[m_ram(a)][m_idx(a)][(a % 4) * 8 +: 8];
    endfunction
    function automatic logic [31:0] mword(int a);
        return exp_mem[m_ram(a)][m_idx(a)][31:0];
    endfunction

    task automatic compare_mem(input string tag);
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < DEPTH; i++)
                check(tag, 64'(mem[r][i]), 64'(exp_mem[r][i]));
    endtask

    task automatic expect_reject(input string tag);
        check({tag, " no select"}, 64'({cap_cs, cap_we}), 64'(0));
        check({tag, " err"}, 64'({r_valid, r_err, r_rmw}), 64'(3'b110));
        check({tag, " zero data"}, 64'({r_rdata, r_chk}), 64'(0));
    endtask

    initial begin : wd
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R12 watchdog: actual hung expected finished");
            report();
        end
    end

    initial begin : main_seq
        logic [7:0]  p;
        logic [31:0] w;
        logic [6:0]  ck;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < DEPTH; i++) exp_mem[r][i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        // R1: quiet after reset
        check("R1 reset rsp", 64'({rsp_valid, rsp_err, rsp_rmw}), 64'(0));
        check("R1 reset ram", 64'({ram_cs, ram_we}), 64'(0));

        // R2, R6: every main byte written with ECC off
        for (int a = 0; a < MAINB; a++) begin
            p = 8'(a * 7 + 3);
            issue(1'b1, a, 2'd0, {24'hA5C3E1, p}, 7'h55);
            check("R2 select", 64'(cap_cs), 64'(1 << m_ram(a)));
            check("R2 index", 64'(cap_idx), 64'(m_idx(a)));
            check("R6 lane enable", 64'(cap_we), 64'(1 << (a % 4)));
            check("R6 lane data", 64'(cap_wd[(a % 4) * 8 +: 8]), 64'(p));
            check("R6 write rsp", 64'({r_valid, r_err, r_rdata}), 64'({1'b1, 1'b0, 32'h0}));
            exp_mem[m_ram(a)][m_idx(a)][(a % 4) * 8 +: 8] = p;
        end
        compare_mem("R2 placement");

        // R3, R10: reads of every size, ECC off
        for (int a = 0; a < MAINB; a++) begin
            issue(1'b0, a, 2'd0, 32'h0, 7'h0);
            check("R3 byte read", 64'({r_err, r_rdata}), 64'({1'b0, 24'h0, mbyte(a)}));
            check("R10 chk off", 64'(r_chk), 64'(0));
        end
        for (int a = 0; a < MAINB; a += 2) begin
            issue(1'b0, a, 2'd1, 32'h0, 7'h0);
            check("R3 half read", 64'({r_err, r_rdata}),
                  64'({1'b0, 16'h0, mbyte(a + 1), mbyte(a)}));
        end
        for (int a = 0; a < MAINB; a += 4) begin
            issue(1'b0, a, 2'd2, 32'h0, 7'h0);
            check("R3 word read", 64'({r_err, r_rdata}), 64'({1'b0, mword(a)}));
        end

        // R6: halfword write enables two lanes only
        issue(1'b1, 6, 2'd1, 32'hFFFF_BEEF, 7'h0);
        check("R6 half enable", 64'(cap_we), 64'(5'b01100));
        check("R6 half data", 64'(cap_wd[31:16]), 64'(16'hBEEF));
        exp_mem[0][1][31:16] = 16'hBEEF;

        // R7: extra region, every offset
        for (int o = 0; o < EXTB; o++) begin
            p = 8'(o * 13 + 8'h40);
            issue(1'b1, MAINB + o, 2'd0, {24'h0F0F0F, p}, 7'h7F);
            check("R7 select", 64'(cap_cs), 64'(1 << x_ram(o)));
            check("R7 index", 64'(cap_idx), 64'(x_idx(o)));
            check("R7 lane4 only", 64'(cap_we), 64'(5'b10000));
            check("R7 lane4 data", 64'(cap_wd[39:32]), 64'(p));
            exp_mem[x_ram(o)][x_idx(o)][39:32] = p;
        end
        for (int o = 0; o < EXTB; o++) begin
            issue(1'b0, MAINB + o, 2'd0, 32'h0, 7'h0);
            check("R7 extra read", 64'({r_err, r_rdata}),
                  64'({1'b0, 24'h0, exp_mem[x_ram(o)][x_idx(o)][39:32]}));
        end
        for (int a = 0; a < MAINB; a += 4) begin
            issue(1'b0, a, 2'd2, 32'h0, 7'h0);
            check("R7 main intact", 64'(r_rdata), 64'(mword(a)));
        end
        compare_mem("R7 placement");

        // R8: wide accesses to the extra region
        for (int o = 0; o < EXTB; o++) begin
            for (int s = 1; s < 4; s++) begin
                issue(1'b1, MAINB + o, 2'(s), 32'hFFFF_FFFF, 7'h7F);
                expect_reject("R8 wide extra");
            end
        end
        compare_mem("R8 no write");

        // R3: misaligned and illegal sizes
        for (int a = 0; a < MAINB; a++) begin
            if (a % 2 != 0) begin
                issue(1'b1, a, 2'd1, 32'hDEAD_DEAD, 7'h0);
                expect_reject("R3 odd half");
            end
            if (a % 4 != 0) begin
                issue(1'b0, a, 2'd2, 32'h0, 7'h0);
                expect_reject("R3 unaligned word");
            end
            if (a % 16 == 0) begin
                issue(1'b1, a, 2'd3, 32'h0, 7'h0);
                expect_reject("R3 illegal size");
            end
        end
        compare_mem("R3 no write");

        // R11: above the extra window
        for (int a = MAINB + EXTB; a < 256; a++) begin
            issue(1'b1, a, 2'd0, 32'h77, 7'h0);
            expect_reject("R11 unmapped");
        end
        compare_mem("R11 no write");

        // R4, R10: ECC on, full-word writes and reads
        @(negedge clk); ecc_on = 1'b1;
        for (int a = 0; a < MAINB; a += 4) begin
            w  = (32'(a) * 32'h0101_0101) ^ 32'h3C5A_96F0;
            ck = 7'(a * 3 + 1);
            issue(1'b1, a, 2'd2, w, ck);
            check("R4 all lanes", 64'(cap_we), 64'(5'b11111));
            check("R4 select", 64'({cap_cs, cap_idx}), 64'({2'(1 << m_ram(a)), 4'(m_idx(a))}));
            check("R4 phys word", 64'(cap_wd), 64'({1'b0, ck, w}));
            check("R4 no rmw", 64'({r_valid, r_err, r_rmw}), 64'(3'b100));
            exp_mem[m_ram(a)][m_idx(a)] = {1'b0, ck, w};
        end
        for (int a = 0; a < MAINB; a++) begin
            issue(1'b0, a, (a % 4 == 0) ? 2'd2 : 2'd0, 32'h0, 7'h0);
            if (a % 4 == 0)
                check("R10 word read", 64'(r_rdata), 64'(mword(a)));
            else
                check("R10 byte read", 64'(r_rdata), 64'(mbyte(a)));
            check("R10 chk on", 64'(r_chk), 64'(exp_mem[m_ram(a)][m_idx(a)][38:32]));
        end

        // R5: sub-word writes under ECC become read-modify-write
        for (int a = 0; a < MAINB; a++) begin
            issue(1'b1, a, (a % 2 == 0) ? 2'd1 : 2'd0, 32'hFFFF_FF00, 7'h11);
            check("R5 no enable", 64'(cap_we), 64'(0));
            check("R5 read select", 64'(cap_cs), 64'(1 << m_ram(a)));
            check("R5 rmw flag", 64'({r_valid, r_err, r_rmw}), 64'(3'b101));
            check("R5 whole word", 64'(r_rdata), 64'(mword(a)));
            check("R5 check bits", 64'(r_chk), 64'(exp_mem[m_ram(a)][m_idx(a)][38:32]));
        end
        compare_mem("R5 memory unchanged");

        // R9: extra window while ECC is on
        for (int o = 0; o < EXTB; o++) begin
            issue(1'b1, MAINB + o, 2'd0, 32'h5A, 7'h3);
            expect_reject("R9 window write");
            issue(1'b0, MAINB + o, 2'd0, 32'h0, 7'h0);
            expect_reject("R9 window read");
        end
        compare_mem("R9 no write");

        // R12: response lasts one cycle, none while idle
        issue(1'b0, 0, 2'd2, 32'h0, 7'h0);
        check("R12 response present", 64'(r_valid), 64'(1));
        @(negedge clk); #0.5;
        check("R12 response gone", 64'({rsp_valid, rsp_err, rsp_rmw}), 64'(0));
        check("R1 idle ram", 64'({ram_cs, ram_we}), 64'(0));

        done = 1'b1;
        report();
    end

endmodule